// File: doc/BRIEF.md
# Auto Scrub Symbol Sequencer

The sequencer sits between a reconfiguration trigger and the port configuration switch. When the trigger fires with scrubbing enabled, it holds back the switch change. During that time it replaces the line data on every port that is about to be reconfigured: first a fixed preamble of two invalid symbols, then idle symbol pairs for a time set by software. When the idle flush has run for the programmed number of symbol-pair ticks, a one-cycle done strobe tells the switch logic that the new setting may be applied. With scrubbing disabled, the trigger is passed straight through as a done strobe.

The scrub timer is a 16-bit up-counter. It advances on a prescaled tick that arrives once per symbol pair, so a flush of about 10 ms fits at the line symbol rate. Its upper byte is always visible on a snapshot output. The threshold and the port change mask are captured when the trigger is accepted. A trigger that arrives while a scrub is running is dropped.

Top module: `scrub_seq_top`

## Requirements
- R1: After reset, every per-port source code is 00 (line data), done is low and the timer snapshot is 0.
- R2: A trigger sampled while idle with the enable input low makes done high for exactly the following cycle, and no port leaves code 00.
- R3: A trigger sampled while idle with the enable input high makes every port whose mask bit is set output code 01 (invalid symbol) for exactly 2 cycles, starting the cycle after the trigger.
- R4: Directly after the invalid preamble, the masked ports output code 10 (idle pair) until the timer, cleared at the trigger, has counted the captured threshold number of ticks. With the tick high on every cycle, this phase lasts threshold+1 cycles, and done rises the cycle after it ends, that is 3+threshold cycles after the trigger edge.
- R5: Ports whose mask bit is clear stay at code 00 throughout a scrub. All ports show 00 whenever the sequencer is idle.
- R6: The timer advances only on cycles where the tick input is high. Each flush cycle without a tick lengthens the idle phase by one cycle.
- R7: The snapshot output equals the upper 8 bits of the 16-bit scrub timer. The timer is cleared when a scrub starts and holds its final value after the scrub ends.
- R8: A trigger that arrives while a scrub is in progress is ignored: the timing of that scrub and its port mask are unchanged.
- R9: Done is a single-cycle strobe, and all ports are back at code 00 in the cycle done is high.
- R10: The threshold is captured when the trigger is accepted. Changing the threshold input during a scrub does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Reconfiguration trigger |
| scrub_en_i | input | 1 | Enables scrubbing on trigger |
| thresh_i | input | TIMER_W | Idle-flush length in ticks |
| tick_i | input | 1 | One pulse per symbol pair |
| chg_mask_i | input | NUM_PORTS | Ports whose configuration will change |
| src_sel_o | output | 2*NUM_PORTS | Per-port source code: 00 line, 01 invalid, 10 idle |
| done_o | output | 1 | Switch change may proceed (one cycle) |
| timer_snap_o | output | SNAP_W | Upper bits of the scrub timer |

## Verification
The bound checker checks on every cycle that the ports show line data whenever the sequencer is idle and in the done cycle. It also checks that done never lasts two cycles, that the invalid preamble is exactly two cycles and is followed by the flush, that the timer never passes its captured limit, that the limit cannot change mid-scrub, and that a disabled trigger produces an immediate done. Only the bench scenarios can show the end-to-end counts: how many invalid and idle cycles each port receives for a given mask, threshold and tick stall, the exact cycle done arrives, the snapshot values mid-run and after a long flush, and that retriggers and mask changes during a scrub leave those counts unchanged.

// File: rtl/scrub_seq_pkg.sv
package scrub_seq_pkg;

    localparam int SRC_W        = 2;
    localparam int PREAMBLE_LEN = 2;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_PREAMBLE = 2'd1,
        PH_FLUSH    = 2'd2
    } phase_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_LINE    = 2'b00,
        SRC_INVALID = 2'b01,
        SRC_IDLE    = 2'b10
    } src_e;

    // Source code for one port given the sequencer phase and its mask bit
    function automatic src_e phase_src(phase_e ph, logic port_sel);
        src_e s;
        s = SRC_LINE;
        if (port_sel) begin
            case (ph)
                PH_PREAMBLE: s = SRC_INVALID;
                PH_FLUSH:    s = SRC_IDLE;
                default:     s = SRC_LINE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/scrub_phase_ctrl.sv
module scrub_phase_ctrl
    import scrub_seq_pkg::*;
#(
    parameter int PRE_LEN = PREAMBLE_LEN
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   trig,
    input  logic   enable,
    input  logic   expired,
    output phase_e phase,
    output logic   accept,
    output logic   done
);
    localparam int CW = (PRE_LEN > 2) ? $clog2(PRE_LEN) : 1;

    logic [CW-1:0] pre_cnt;
    logic          bypass;

    assign accept = trig && (phase == PH_IDLE) && enable;
    assign bypass = trig && (phase == PH_IDLE) && !enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            pre_cnt <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase   <= PH_PREAMBLE;
                        pre_cnt <= '0;
                    end
                    if (bypass) done <= 1'b1;
                end
                PH_PREAMBLE: begin
                    if (pre_cnt == CW'(PRE_LEN - 1)) phase <= PH_FLUSH;
                    else                             pre_cnt <= pre_cnt + 1'b1;
                end
                PH_FLUSH: begin
                    if (expired) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scrub_timer.sv
module scrub_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] thr_in,
    output logic [W-1:0] count,
    output logic [W-1:0] limit,
    output logic         expired
);
    assign expired = (count == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            limit <= '0;
        end else if (clear) begin
            count <= '0;
            limit <= thr_in;
        end else if (run && tick && !expired) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/scrub_port_sel.sv
module scrub_port_sel
    import scrub_seq_pkg::*;
#(
    parameter int N = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [N-1:0]       mask_in,
    input  phase_e             phase,
    output logic [SRC_W*N-1:0] sel
);
    logic [N-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '0;
        else if (load) mask_q <= mask_in;
    end

    for (genvar p = 0; p < N; p++) begin : g_port
        assign sel[p*SRC_W +: SRC_W] = phase_src(phase, mask_q[p]);
    end
endmodule

// File: rtl/scrub_seq_top.sv
module scrub_seq_top
    import scrub_seq_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int TIMER_W   = 16,
    parameter int SNAP_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       trig_i,
    input  logic                       scrub_en_i,
    input  logic [TIMER_W-1:0]         thresh_i,
    input  logic                       tick_i,
    input  logic [NUM_PORTS-1:0]       chg_mask_i,
    output logic [SRC_W*NUM_PORTS-1:0] src_sel_o,
    output logic                       done_o,
    output logic [SNAP_W-1:0]          timer_snap_o
);
    phase_e             phase;
    logic               accept;
    logic               expired;
    logic [TIMER_W-1:0] count;
    logic [TIMER_W-1:0] limit;

    scrub_phase_ctrl #(.PRE_LEN(PREAMBLE_LEN)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig_i),
        .enable  (scrub_en_i),
        .expired (expired),
        .phase   (phase),
        .accept  (accept),
        .done    (done_o)
    );

    scrub_timer #(.W(TIMER_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .run     (phase == PH_FLUSH),
        .tick    (tick_i),
        .thr_in  (thresh_i),
        .count   (count),
        .limit   (limit),
        .expired (expired)
    );

    scrub_port_sel #(.N(NUM_PORTS)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .mask_in (chg_mask_i),
        .phase   (phase),
        .sel     (src_sel_o)
    );

    assign timer_snap_o = count[TIMER_W-1 -: SNAP_W];
endmodule

// File: rtl/scrub_seq_chk.sv
module scrub_seq_chk
    import scrub_seq_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int TIMER_W   = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       trig,
    input logic                       enable,
    input phase_e                     phase,
    input logic                       done,
    input logic [SRC_W*NUM_PORTS-1:0] sel,
    input logic [TIMER_W-1:0]         count,
    input logic [TIMER_W-1:0]         limit
);
    assert_idle_line_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (sel == '0));

    assert_done_line_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (sel == '0));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && trig && !enable) |=> (done && phase == PH_IDLE));

    // preamble length fixed at two cycles
    assert_pre_first_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PREAMBLE && $past(phase) != PH_PREAMBLE) |=> (phase == PH_PREAMBLE));

    assert_pre_second_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PREAMBLE && $past(phase) == PH_PREAMBLE) |=> (phase == PH_FLUSH));

    assert_timer_bound_R4: assert property (@(posedge clk) disable iff (rst)
        count <= limit);

    assert_limit_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> $stable(limit));
endmodule

bind scrub_seq_top scrub_seq_chk #(.NUM_PORTS(NUM_PORTS), .TIMER_W(TIMER_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .trig   (trig_i),
    .enable (scrub_en_i),
    .phase  (phase),
    .done   (done_o),
    .sel    (src_sel_o),
    .count  (count),
    .limit  (limit)
);

// File: tb/scrub_seq_top_test.sv
module scrub_seq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;
    localparam int TW = 16;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig = 1'b0;
    logic          scrub_en = 1'b0;
    logic [TW-1:0] thresh = '0;
    logic          tick = 1'b0;
    logic [NP-1:0] chg_mask = '0;
    logic [2*NP-1:0] src_sel;
    logic          done;
    logic [SW-1:0] snap;

    int tests = 0;
    int fails = 0;

    int r_inv [NP];
    int r_idle[NP];
    int r_bad, r_done_idx, r_done_cnt, r_dirty_done, r_snap0, r_snap_mid;

    always #(CLK_PERIOD/2) clk = ~clk;

    scrub_seq_top #(.NUM_PORTS(NP), .TIMER_W(TW), .SNAP_W(SW)) uut (
        .clk          (clk),
        .rst          (rst),
        .trig_i       (trig),
        .scrub_en_i   (scrub_en),
        .thresh_i     (thresh),
        .tick_i       (tick),
        .chg_mask_i   (chg_mask),
        .src_sel_o    (src_sel),
        .done_o       (done),
        .timer_snap_o (snap)
    );

    typedef struct packed {
        logic          en;
        logic [NP-1:0] mask;
        logic [TW-1:0] thr;
        logic [7:0]    stall;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 2'b11, 16'd3, 8'd0},
        '{1'b1, 2'b01, 16'd0, 8'd0},
        '{1'b1, 2'b10, 16'd5, 8'd4},
        '{1'b0, 2'b11, 16'd7, 8'd0},
        '{1'b1, 2'b00, 16'd2, 8'd0},
        '{1'b1, 2'b11, 16'd1, 8'd2}
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Trigger one scrub and record what every port shows, sample by sample
    task automatic run_scrub(input logic en, input logic [NP-1:0] mask,
                             input logic [TW-1:0] thr, input int stall,
                             input int retrig_at, input int thrchg_at);
        for (int p = 0; p < NP; p++) begin
            r_inv[p] = 0;
            r_idle[p] = 0;
        end
        r_bad = 0; r_done_idx = -1; r_done_cnt = 0; r_dirty_done = 0;
        r_snap0 = -1; r_snap_mid = -1;
        @(negedge clk);
        scrub_en = en; chg_mask = mask; thresh = thr; tick = 1'b0; trig = 1'b1;
        for (int k = 0; k < int'(thr) + stall + 8; k++) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                case (src_sel[p*2 +: 2])
                    2'b01:   r_inv[p]++;
                    2'b10:   r_idle[p]++;
                    2'b00:   ;
                    default: r_bad++;
                endcase
            end
            if (done) begin
                if (r_done_idx < 0) r_done_idx = k;
                r_done_cnt++;
                if (src_sel != '0) r_dirty_done++;
            end
            if (k == 0)   r_snap0 = int'(snap);
            if (k == 302) r_snap_mid = int'(snap);
            trig = (k == retrig_at);
            if (k == retrig_at) chg_mask = ~mask;
            if (k == thrchg_at) thresh = thr + 16'd9;
            tick = (k >= 2 + stall);
        end
        trig = 1'b0; tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sel after reset", int'(src_sel), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 snapshot after reset", int'(snap), 0);

        foreach (VECS[i]) begin
            vec_t v;
            int exp_done;
            v = VECS[i];
            run_scrub(v.en, v.mask, v.thr, int'(v.stall), -1, -1);
            exp_done = v.en ? 3 + int'(v.thr) + int'(v.stall) : 0;
            for (int p = 0; p < NP; p++) begin
                chk($sformatf("R3/R5 vec%0d port%0d invalid cycles", i, p), r_inv[p],
                    (v.en && v.mask[p]) ? 2 : 0);
                chk($sformatf("R4/R6/R5 vec%0d port%0d idle cycles", i, p), r_idle[p],
                    (v.en && v.mask[p]) ? int'(v.thr) + 1 + int'(v.stall) : 0);
            end
            chk($sformatf("R2/R4 vec%0d done index", i), r_done_idx, exp_done);
            chk($sformatf("R9 vec%0d done width", i), r_done_cnt, 1);
            chk($sformatf("R9 vec%0d sel at done", i), r_dirty_done, 0);
            chk($sformatf("R5 vec%0d illegal codes", i), r_bad, 0);
            repeat (2) @(negedge clk);
        end

        // R7: long flush exposes upper timer byte
        run_scrub(1'b1, 2'b01, 16'd600, 0, -1, -1);
        chk("R7 snapshot mid-scrub (count 300)", r_snap_mid, 1);
        chk("R7 snapshot holds final count 600", int'(snap), 2);
        chk("R4 long flush idle cycles", r_idle[0], 601);
        run_scrub(1'b1, 2'b10, 16'd1, 0, -1, -1);
        chk("R7 timer cleared at new scrub", r_snap0, 0);

        // R8: retrigger with a different mask during the flush
        run_scrub(1'b1, 2'b01, 16'd10, 0, 3, -1);
        chk("R8 retrigger keeps done index", r_done_idx, 13);
        chk("R8 retrigger keeps mask port0", r_idle[0], 11);
        chk("R8 retrigger keeps mask port1", r_idle[1], 0);
        chk("R8 single done after retrigger", r_done_cnt, 1);

        // R8: retrigger during the preamble
        run_scrub(1'b1, 2'b10, 16'd4, 0, 0, -1);
        chk("R8 preamble retrigger invalid port1", r_inv[1], 2);
        chk("R8 preamble retrigger done index", r_done_idx, 7);

        // R10: threshold input changes mid-scrub
        run_scrub(1'b1, 2'b11, 16'd6, 0, -1, 4);
        chk("R10 threshold change ignored done", r_done_idx, 9);
        chk("R10 threshold change ignored idle", r_idle[1], 7);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule